// File: doc/BRIEF.md
# Core Timing Emergency Monitor

This block sits beside one processor core and watches the samples coming from that core's critical-path delay sensor. Over a measurement window it counts how many valid samples exceed a programmable delay threshold. That count is the emergency level. It also averages the valid samples into a mean delay. The mean tracks the slow part of the delay, which comes from the manufacturing corner and the die temperature. The fast supply-noise part does not show up in it.

A window ends when a pulse arrives on the window-end input. On that pulse the block publishes the emergency level and the mean delay. It also publishes a two-point linear forecast of each for the next window, taken from the current window and the one before it. It then clears its accumulators and raises a done strobe for one cycle. A thread-migration controller reads these four values and picks which core should take the most demanding thread. The mean is a right shift of the sum by the log2 of the nominal samples per window, so the block has no divider.

Top module: `tim_emerg_mon`

## Requirements
- R1: After reset, emerg_level, pt_mean, emerg_pred, pt_pred and win_done are all zero.
- R2: A sample is an emergency only when smp_vld is 1 and smp_code is strictly greater than thr_code. A code equal to the threshold is not counted. A sample with smp_vld at 0 is not counted, whatever its code.
- R3: The emergency count stops at 2^CW-1 and does not wrap back to zero.
- R4: pt_mean equals floor(S / 2^LOG2_N), where S is the sum of the valid smp_code values in the window. S itself stops at 2^(DW+LOG2_N)-1 and does not wrap.
- R5: A valid sample presented in the same cycle as win_end belongs to the window that is closing. The next window starts from a count and a sum of zero.
- R6: The four result outputs take their new values, and win_done is 1, exactly in the cycle after win_end. In every other cycle win_done is 0 and the result outputs hold their values.
- R7: Each prediction equals 2·current − previous, where previous is the value published at the prior window end (zero after reset). A result below zero is clamped to 0, and a result above the output's full scale is clamped to full scale (2^CW-1 for the level, 2^DW-1 for the mean).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sensor sample is valid this cycle |
| smp_code | input | DW | Sampled delay code |
| thr_code | input | DW | Emergency delay threshold |
| win_end | input | 1 | Last cycle of the measurement window |
| emerg_level | output | CW | Emergencies counted in the last window |
| pt_mean | output | DW | Mean delay of the last window |
| emerg_pred | output | CW | Forecast emergency level for the next window |
| pt_pred | output | DW | Forecast mean delay for the next window |
| win_done | output | 1 | One-cycle strobe: new results published |

## Verification
A wrong count or sum inside the block is not visible until the next window closes. It then shows up, one cycle after win_end, as a wrong emerg_level or pt_mean. Both predictions are built from the published values, so a bad previous value shows up in them one window later. The bench therefore closes many short windows and compares all five outputs on every cycle. It includes windows that drive the counter and the sum into saturation, windows that drive the forecasts to both clamps, and windows whose last sample arrives together with win_end.

// File: rtl/temon_pkg.sv
package temon_pkg;
   typedef enum logic [0:0] {
      PRED_HOLD   = 1'b0,
      PRED_LINEAR = 1'b1
   } pred_mode_e;
endpackage

// File: rtl/temon_excess_count.sv
module temon_excess_count #(
   parameter int DW = 8,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          smp_vld,
   input  logic [DW-1:0] smp_code,
   input  logic [DW-1:0] thr_code,
   output logic [CW-1:0] cnt_nxt
);
   logic [CW-1:0] cnt_q;
   logic          hit;
   logic          full;

   assign hit  = smp_vld && (smp_code > thr_code);
   assign full = &cnt_q;

   always_comb begin
      cnt_nxt = cnt_q;
      if (hit && !full)
         cnt_nxt = cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/temon_mean_acc.sv
module temon_mean_acc #(
   parameter int DW     = 8,
   parameter int LOG2_N = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          smp_vld,
   input  logic [DW-1:0] smp_code,
   output logic [DW-1:0] mean_nxt
);
   localparam int AW = DW + LOG2_N;

   logic [AW-1:0] sum_q;
   logic [AW-1:0] sum_nxt;
   logic [AW:0]   sum_ext;

   assign sum_ext = {1'b0, sum_q} + {{(LOG2_N + 1){1'b0}}, smp_code};

   always_comb begin
      sum_nxt = sum_q;
      if (smp_vld)
         sum_nxt = sum_ext[AW] ? {AW{1'b1}} : sum_ext[AW-1:0];
   end

   assign mean_nxt = sum_nxt[AW-1:LOG2_N];

   always_ff @(posedge clk) begin
      if (!rst_n)   sum_q <= '0;
      else if (clr) sum_q <= '0;
      else          sum_q <= sum_nxt;
   end
endmodule

// File: rtl/temon_lin_pred.sv
module temon_lin_pred
   import temon_pkg::*;
#(
   parameter int         W    = 8,
   parameter pred_mode_e MODE = PRED_LINEAR
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prev,
   output logic [W-1:0] pred
);
   generate
      if (MODE == PRED_LINEAR) begin : g_linear
         logic [W+1:0] twice;
         logic [W+1:0] diff;
         assign twice = {1'b0, cur, 1'b0};
         assign diff  = twice - {2'b00, prev};
         always_comb begin
            if (diff[W+1])   pred = '0;
            else if (diff[W]) pred = {W{1'b1}};
            else              pred = diff[W-1:0];
         end
      end else begin : g_hold
         assign pred = cur;
      end
   endgenerate
endmodule

// File: rtl/tim_emerg_mon.sv
module tim_emerg_mon
   import temon_pkg::*;
#(
   parameter int         DW        = 8,
   parameter int         CW        = 16,
   parameter int         LOG2_N    = 4,
   parameter pred_mode_e PRED_MODE = PRED_LINEAR
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_vld,
   input  logic [DW-1:0] smp_code,
   input  logic [DW-1:0] thr_code,
   input  logic          win_end,
   output logic [CW-1:0] emerg_level,
   output logic [DW-1:0] pt_mean,
   output logic [CW-1:0] emerg_pred,
   output logic [DW-1:0] pt_pred,
   output logic          win_done
);
   generate
      if (DW < 1 || DW > 24) begin : g_bad_dw
         $error("tim_emerg_mon: DW out of range");
      end
      if (CW < 1 || CW > 32) begin : g_bad_cw
         $error("tim_emerg_mon: CW out of range");
      end
      if (LOG2_N < 0 || LOG2_N > 24) begin : g_bad_n
         $error("tim_emerg_mon: LOG2_N out of range");
      end
   endgenerate

   logic [CW-1:0] cnt_nxt;
   logic [DW-1:0] mean_nxt;
   logic [CW-1:0] lvl_fc;
   logic [DW-1:0] mean_fc;

   temon_excess_count #(.DW(DW), .CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (win_end),
      .smp_vld  (smp_vld),
      .smp_code (smp_code),
      .thr_code (thr_code),
      .cnt_nxt  (cnt_nxt)
   );

   temon_mean_acc #(.DW(DW), .LOG2_N(LOG2_N)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (win_end),
      .smp_vld  (smp_vld),
      .smp_code (smp_code),
      .mean_nxt (mean_nxt)
   );

   // Published values double as the previous-window history.
   temon_lin_pred #(.W(CW), .MODE(PRED_MODE)) u_pred_lvl (
      .cur  (cnt_nxt),
      .prev (emerg_level),
      .pred (lvl_fc)
   );

   temon_lin_pred #(.W(DW), .MODE(PRED_MODE)) u_pred_mean (
      .cur  (mean_nxt),
      .prev (pt_mean),
      .pred (mean_fc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         emerg_level <= '0;
         pt_mean     <= '0;
         emerg_pred  <= '0;
         pt_pred     <= '0;
         win_done    <= 1'b0;
      end else begin
         win_done <= win_end;
         if (win_end) begin
            emerg_level <= cnt_nxt;
            pt_mean     <= mean_nxt;
            emerg_pred  <= lvl_fc;
            pt_pred     <= mean_fc;
         end
      end
   end
endmodule

// File: rtl/tim_emerg_mon_chk.sv
module tim_emerg_mon_chk #(
   parameter int DW = 8,
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          win_end,
   input logic [CW-1:0] emerg_level,
   input logic [DW-1:0] pt_mean,
   input logic [CW-1:0] emerg_pred,
   input logic [DW-1:0] pt_pred,
   input logic          win_done
);
   p_done_follows_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (win_done == $past(win_end)));

   p_level_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(win_end)) |-> ($stable(emerg_level) && $stable(emerg_pred)));

   p_mean_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(win_end)) |-> ($stable(pt_mean) && $stable(pt_pred)));

   p_level_pred_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_done && emerg_level == '0) |-> (emerg_pred == '0));

   p_mean_pred_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_done && pt_mean == '0) |-> (pt_pred == '0));
endmodule

bind tim_emerg_mon tim_emerg_mon_chk #(.DW(DW), .CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .win_end     (win_end),
   .emerg_level (emerg_level),
   .pt_mean     (pt_mean),
   .emerg_pred  (emerg_pred),
   .pt_pred     (pt_pred),
   .win_done    (win_done)
);

// File: tb/tim_emerg_mon_bench.sv
module tim_emerg_mon_bench;
   localparam int DW     = 8;
   localparam int CW     = 6;
   localparam int LOG2_N = 3;
   localparam int CMAX   = (1 << CW) - 1;
   localparam int DMAX   = (1 << DW) - 1;
   localparam int SMAX   = (1 << (DW + LOG2_N)) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_vld = 1'b0;
   logic [DW-1:0] smp_code = '0;
   logic [DW-1:0] thr_code = '0;
   logic          win_end = 1'b0;
   logic [CW-1:0] emerg_level;
   logic [DW-1:0] pt_mean;
   logic [CW-1:0] emerg_pred;
   logic [DW-1:0] pt_pred;
   logic          win_done;

   always #5 clk = ~clk;

   tim_emerg_mon #(.DW(DW), .CW(CW), .LOG2_N(LOG2_N)) u_tim_emerg_mon (
      .clk, .rst_n, .smp_vld, .smp_code, .thr_code, .win_end,
      .emerg_level, .pt_mean, .emerg_pred, .pt_pred, .win_done
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int m_cnt = 0, m_sum = 0;
   int x_lvl = 0, x_mean = 0, x_plvl = 0, x_pmean = 0, x_done = 0;

   function automatic int clamp(input int v, input int hi);
      if (v < 0) return 0;
      if (v > hi) return hi;
      return v;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // Compare outputs with the model, then apply one cycle of stimulus.
   task automatic cycle(input bit v, input int d, input int thr, input bit we);
      @(negedge clk);
      chk("R2/R3 emerg_level", int'(emerg_level), x_lvl);
      chk("R4 pt_mean", int'(pt_mean), x_mean);
      chk("R7 emerg_pred", int'(emerg_pred), x_plvl);
      chk("R7 pt_pred", int'(pt_pred), x_pmean);
      chk("R6 win_done", int'(win_done), x_done);
      smp_vld  = v;
      smp_code = DW'(d);
      thr_code = DW'(thr);
      win_end  = we;
      if (v && d > thr && m_cnt < CMAX) m_cnt++;
      if (v) m_sum = (m_sum + d > SMAX) ? SMAX : m_sum + d;
      x_done = we;
      if (we) begin
         x_plvl  = clamp(2 * m_cnt - x_lvl, CMAX);
         x_pmean = clamp(2 * (m_sum >> LOG2_N) - x_mean, DMAX);
         x_lvl   = m_cnt;
         x_mean  = m_sum >> LOG2_N;
         m_cnt   = 0;
         m_sum   = 0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values
      chk("R1 emerg_level", int'(emerg_level), 0);
      chk("R1 pt_mean", int'(pt_mean), 0);
      chk("R1 emerg_pred", int'(emerg_pred), 0);
      chk("R1 pt_pred", int'(pt_pred), 0);
      chk("R1 win_done", int'(win_done), 0);
      rst_n = 1'b1;

      // R2: equal to threshold and invalid samples do not count
      for (int i = 0; i < 8; i++) cycle(1, 100, 100, 0);
      for (int i = 0; i < 8; i++) cycle(0, 250, 100, 0);
      cycle(1, 101, 100, 1);
      cycle(0, 0, 100, 0);
      chk("R2 one exceedance only", int'(emerg_level), 1);

      // R5: sample on window-end cycle counts; next window starts clean
      cycle(0, 0, 10, 0);
      cycle(1, 200, 10, 1);
      cycle(0, 0, 10, 1);
      cycle(0, 0, 10, 0);
      chk("R5 cleared window level", int'(emerg_level), 0);
      chk("R7 pred floor", int'(emerg_pred), 0);

      // R3/R4: counter and sum saturation; R7 top clamp
      for (int i = 0; i < 5; i++) cycle(1, 20, 10, 0);
      cycle(1, 20, 10, 1);
      for (int i = 0; i < 80; i++) cycle(1, 255, 0, 0);
      cycle(1, 255, 0, 1);
      cycle(0, 0, 0, 0);
      chk("R3 saturated level", int'(emerg_level), CMAX);
      chk("R4 saturated mean", int'(pt_mean), DMAX);
      chk("R7 clamp top", int'(emerg_pred), CMAX);
      // R7: bottom clamp after a full window
      cycle(0, 0, 0, 1);
      cycle(0, 0, 0, 0);
      chk("R7 clamp bottom", int'(pt_pred), 0);

      // Random windows
      for (int w = 0; w < 300; w++) begin
         int len = 1 + int'($urandom_range(0, 15));
         int thr = int'($urandom_range(0, DMAX));
         for (int c = 0; c < len; c++)
            cycle(bit'($urandom_range(0, 1)), int'($urandom_range(0, DMAX)), thr,
                  c == len - 1);
      end
      cycle(0, 0, 0, 0);
      cycle(0, 0, 0, 0);
      finish_run();
   end
endmodule